// File: doc/BRIEF.md
# Banked byte memory with shared and per-bank regions

This block is the data memory of a small byte-oriented processor core. An access names a 7-bit offset, and the block joins it with a bank number held in an internal bank register to decide which storage the access reaches. The offset range is split into four regions. The lowest twelve offsets are core registers, and the bank register is one of them. Every bank reaches the same copy of the core registers. The next twenty offsets are a special-function window with separate storage per bank. Here it is a plain placeholder byte array that only the lowest `SFR_BANKS` banks implement. Eighty bytes of general RAM follow, also separate per bank. The last sixteen offsets are a common window that every bank shares.

The core drives one synchronous write port and one combinational read port, both relative to the current bank. It can also load a literal bank number with a dedicated strobe. A second port addresses the general RAM of all banks as one flat range that starts at `LIN_BASE`. Through this port the general RAM of bank b, offset 0x20+k, is byte b*80+k. Unimplemented locations read as zero and ignore writes.

Top module: `banked_dmem`

## Requirements
- R1: After reset the bank register is zero and every location, on both ports, reads zero.
- R2: Offsets 0x00–0x0B except 0x08 are core registers. A byte written there from any bank reads back the same from every bank.
- R3: Offset 0x08 reads the bank register, zero-extended. A write to offset 0x08 loads the low bits of the data into the bank register, and the next access after that edge uses the new bank.
- R4: A bank-load strobe copies `bsel_lit` into the bank register. If a write to offset 0x08 happens in the same cycle, the strobe takes priority.
- R5: Offsets 0x0C–0x1F in banks below `SFR_BANKS` (default 4) are separate bytes for each bank.
- R6: Offsets 0x0C–0x1F in banks at or above `SFR_BANKS` read zero and ignore writes.
- R7: Offsets 0x20–0x6F are 80 separate bytes in each bank.
- R8: Offsets 0x70–0x7F reach the same 16 bytes from every bank.
- R9: Linear address `LIN_BASE`+n (default 0x2000) reads and writes the general RAM byte at bank n/80, offset 0x20+(n mod 80), for n below 80·`NUM_BANKS`.
- R10: Linear addresses below `LIN_BASE` or at and above `LIN_BASE`+80·`NUM_BANKS` read zero, and writes to them change nothing.
- R11: Writes take effect at the clock edge and reads are combinational. If the banked port and the linear port write the same byte in one cycle, the linear data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bsel_load | input | 1 | Load `bsel_lit` into the bank register |
| bsel_lit | input | BANK_W | Literal bank number |
| wr_en | input | 1 | Banked write strobe |
| wr_off | input | 7 | Banked write offset |
| wr_data | input | 8 | Banked write data |
| rd_off | input | 7 | Banked read offset |
| rd_data | output | 8 | Banked read data (combinational) |
| lin_wr_en | input | 1 | Linear write strobe |
| lin_addr | input | LIN_W | Linear address (shared by read and write) |
| lin_wdata | input | 8 | Linear write data |
| lin_rdata | output | 8 | Linear read data (combinational) |
| bank_q | output | BANK_W | Current bank register |

## Verification
The mirror properties assume that in the cycle after a shared-region write, the read offset is compared against the offset just written. They also assume that no linear write lands in the shared regions, which holds because the linear port can only reach general RAM. The bank-register properties assume that the strobe and the offset-0x08 write are sampled as stable at the clock edge. The stimulus meets this by changing every input on the falling edge and holding it over one full rising edge. Stimulus that raises both writers at once, aimed at the same byte, is confined to the collision case of R11.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
   localparam int BYTE_W = 8;
   localparam int OFF_W  = 7;

   // region boundaries (behavioural: the decoder depends on them)
   localparam logic [OFF_W-1:0] SFR_LO   = 7'h0C;
   localparam logic [OFF_W-1:0] GPR_LO   = 7'h20;
   localparam logic [OFF_W-1:0] COM_LO   = 7'h70;
   localparam logic [OFF_W-1:0] BSEL_OFF = 7'h08;

   localparam int CORE_N = 12;
   localparam int SFR_N  = 20;
   localparam int GPR_N  = 80;
   localparam int COM_N  = 16;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_CORE,
      RG_SFR,
      RG_GPR,
      RG_COM
   } region_e;
endpackage

// File: rtl/dmem_store.sv
module dmem_store
   import dmem_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int IDX_W = 8,
   parameter int NWP   = 1,
   parameter int NRP   = 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NWP-1:0]                    we,
   input  logic [NWP-1:0][IDX_W-1:0]         widx,
   input  logic [NWP-1:0][BYTE_W-1:0]        wdata,
   input  logic [NRP-1:0][IDX_W-1:0]         ridx,
   output logic [NRP-1:0][BYTE_W-1:0]        rdata
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 1 || DEPTH > (1 << IDX_W)) begin : g_bad_depth
      $error("dmem_store: DEPTH must fit the index width");
   end
   if (NWP < 1 || NRP < 1) begin : g_bad_ports
      $error("dmem_store: at least one write and one read port");
   end

   logic [BYTE_W-1:0] mem [DEPTH];

   // higher-numbered write port wins on a same-index collision
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         for (int p = 0; p < NWP; p++) begin
            if (we[p] && int'(widx[p]) < DEPTH) mem[AW'(widx[p])] <= wdata[p];
         end
      end
   end

   for (genvar p = 0; p < NRP; p++) begin : g_rd
      assign rdata[p] = (int'(ridx[p]) < DEPTH) ? mem[AW'(ridx[p])] : '0;
   end
endmodule

// File: rtl/dmem_region_dec.sv
module dmem_region_dec
   import dmem_pkg::*;
#(
   parameter int NUM_BANKS = 32,
   parameter int SFR_BANKS = 4,
   parameter int BANK_W    = 5,
   parameter int IDX_W     = 12
) (
   input  logic [BANK_W-1:0] bank,
   input  logic [OFF_W-1:0]  off,
   output region_e           region,
   output logic [IDX_W-1:0]  idx
);
   if (SFR_BANKS > NUM_BANKS) begin : g_bad_sfr
      $error("dmem_region_dec: SFR_BANKS exceeds NUM_BANKS");
   end

   always_comb begin
      region = RG_NONE;
      idx    = '0;
      if (off < SFR_LO) begin
         region = RG_CORE;
         idx    = IDX_W'(off);
      end else if (off < GPR_LO) begin
         if (IDX_W'(bank) < IDX_W'(SFR_BANKS)) begin
            region = RG_SFR;
            idx    = IDX_W'(bank) * IDX_W'(SFR_N) + IDX_W'(off - SFR_LO);
         end
      end else if (off < COM_LO) begin
         region = RG_GPR;
         idx    = IDX_W'(bank) * IDX_W'(GPR_N) + IDX_W'(off - GPR_LO);
      end else begin
         region = RG_COM;
         idx    = IDX_W'(off - COM_LO);
      end
   end
endmodule

// File: rtl/dmem_lin_map.sv
module dmem_lin_map #(
   parameter int LIN_W     = 16,
   parameter int LIN_BASE  = 32'h2000,
   parameter int GPR_TOTAL = 2560,
   parameter int IDX_W     = 12
) (
   input  logic [LIN_W-1:0] lin_addr,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);
   logic [LIN_W-1:0] rel;

   assign rel = lin_addr - LIN_W'(LIN_BASE);
   assign hit = (int'(lin_addr) >= LIN_BASE) && (int'(lin_addr) - LIN_BASE < GPR_TOTAL);
   assign idx = IDX_W'(rel);
endmodule

// File: rtl/banked_dmem.sv
module banked_dmem
   import dmem_pkg::*;
#(
   parameter int NUM_BANKS = 32,
   parameter int SFR_BANKS = 4,
   parameter int LIN_W     = 16,
   parameter int LIN_BASE  = 32'h2000,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bsel_load,
   input  logic [BANK_W-1:0] bsel_lit,
   input  logic              wr_en,
   input  logic [6:0]        wr_off,
   input  logic [7:0]        wr_data,
   input  logic [6:0]        rd_off,
   output logic [7:0]        rd_data,
   input  logic              lin_wr_en,
   input  logic [LIN_W-1:0]  lin_addr,
   input  logic [7:0]        lin_wdata,
   output logic [7:0]        lin_rdata,
   output logic [BANK_W-1:0] bank_q
);
   localparam int GPR_TOTAL = NUM_BANKS * GPR_N;
   localparam int SFR_TOTAL = SFR_BANKS * SFR_N;
   localparam int IDX_W     = $clog2(GPR_TOTAL);

   if (NUM_BANKS < 2 || NUM_BANKS != (1 << BANK_W) || BANK_W > BYTE_W) begin : g_bad_banks
      $error("banked_dmem: NUM_BANKS must be a power of two up to 256");
   end
   if (SFR_BANKS < 1 || SFR_BANKS > NUM_BANKS) begin : g_bad_sfr
      $error("banked_dmem: SFR_BANKS out of range");
   end
   if (LIN_BASE < 0 || LIN_BASE + GPR_TOTAL > (1 << LIN_W)) begin : g_bad_lin
      $error("banked_dmem: linear window does not fit LIN_W");
   end

   // ---------------- bank register ----------------
   logic [BANK_W-1:0] bank_r;
   logic              off8_wr;

   assign off8_wr = wr_en && (wr_off == BSEL_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bank_r <= '0;
      else if (bsel_load) bank_r <= bsel_lit;
      else if (off8_wr)   bank_r <= wr_data[BANK_W-1:0];
   end
   assign bank_q = bank_r;

   // ---------------- decode ----------------
   region_e          wr_reg, rd_reg;
   logic [IDX_W-1:0] wr_idx, rd_idx, lin_idx;
   logic             lin_hit;

   dmem_region_dec #(.NUM_BANKS(NUM_BANKS), .SFR_BANKS(SFR_BANKS), .BANK_W(BANK_W), .IDX_W(IDX_W))
      u_wdec (.bank(bank_r), .off(wr_off), .region(wr_reg), .idx(wr_idx));

   dmem_region_dec #(.NUM_BANKS(NUM_BANKS), .SFR_BANKS(SFR_BANKS), .BANK_W(BANK_W), .IDX_W(IDX_W))
      u_rdec (.bank(bank_r), .off(rd_off), .region(rd_reg), .idx(rd_idx));

   dmem_lin_map #(.LIN_W(LIN_W), .LIN_BASE(LIN_BASE), .GPR_TOTAL(GPR_TOTAL), .IDX_W(IDX_W))
      u_lin (.lin_addr(lin_addr), .hit(lin_hit), .idx(lin_idx));

   // ---------------- storage ----------------
   logic             core_we, sfr_we, com_we, gpr_bank_we, gpr_lin_we;
   logic [7:0]       core_rd, sfr_rd, com_rd;
   logic [1:0][7:0]  gpr_rd;

   assign core_we     = wr_en && (wr_reg == RG_CORE) && (wr_off != BSEL_OFF);
   assign sfr_we      = wr_en && (wr_reg == RG_SFR);
   assign com_we      = wr_en && (wr_reg == RG_COM);
   assign gpr_bank_we = wr_en && (wr_reg == RG_GPR);
   assign gpr_lin_we  = lin_wr_en && lin_hit;

   dmem_store #(.DEPTH(CORE_N), .IDX_W(IDX_W), .NWP(1), .NRP(1)) u_core (
      .clk(clk), .rst_n(rst_n), .we(core_we), .widx(wr_idx), .wdata(wr_data),
      .ridx(rd_idx), .rdata(core_rd));

   dmem_store #(.DEPTH(SFR_TOTAL), .IDX_W(IDX_W), .NWP(1), .NRP(1)) u_sfr (
      .clk(clk), .rst_n(rst_n), .we(sfr_we), .widx(wr_idx), .wdata(wr_data),
      .ridx(rd_idx), .rdata(sfr_rd));

   dmem_store #(.DEPTH(COM_N), .IDX_W(IDX_W), .NWP(1), .NRP(1)) u_com (
      .clk(clk), .rst_n(rst_n), .we(com_we), .widx(wr_idx), .wdata(wr_data),
      .ridx(rd_idx), .rdata(com_rd));

   // port 1 (linear) is later in the write order, so it wins a collision
   dmem_store #(.DEPTH(GPR_TOTAL), .IDX_W(IDX_W), .NWP(2), .NRP(2)) u_gpr (
      .clk(clk), .rst_n(rst_n),
      .we({gpr_lin_we, gpr_bank_we}),
      .widx({lin_idx, wr_idx}),
      .wdata({lin_wdata, wr_data}),
      .ridx({lin_idx, rd_idx}),
      .rdata(gpr_rd));

   // ---------------- read mux ----------------
   always_comb begin
      unique case (rd_reg)
         RG_CORE: rd_data = (rd_off == BSEL_OFF) ? 8'(bank_r) : core_rd;
         RG_SFR:  rd_data = sfr_rd;
         RG_GPR:  rd_data = gpr_rd[0];
         RG_COM:  rd_data = com_rd;
         default: rd_data = '0;
      endcase
   end

   assign lin_rdata = lin_hit ? gpr_rd[1] : '0;

   // ---------------- assertions ----------------
   a_r4_literal_load: assert property (@(posedge clk) disable iff (!rst_n)
      bsel_load |=> bank_q == $past(bsel_lit));

   a_r3_offset8_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_off == 7'h08 && !bsel_load) |=> bank_q == $past(wr_data[BANK_W-1:0]));

   a_r3_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!bsel_load && !(wr_en && wr_off == 7'h08)) |=> $stable(bank_q));

   a_r8_common_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_off >= 7'h70) ##1 (rd_off == $past(wr_off)) |-> rd_data == $past(wr_data));

   a_r2_core_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_off < 7'h0C && wr_off != 7'h08) ##1 (rd_off == $past(wr_off))
      |-> rd_data == $past(wr_data));

   a_r6_sfr_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_off >= 7'h0C && rd_off < 7'h20 && int'(bank_q) >= SFR_BANKS) |-> rd_data == 8'h00);

   a_r10_lin_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(lin_addr) < LIN_BASE) |-> lin_rdata == 8'h00);

   a_r10_lin_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(lin_addr) >= LIN_BASE + GPR_TOTAL) |-> lin_rdata == 8'h00);
endmodule

// File: tb/banked_dmem_tb_top.sv
module banked_dmem_tb_top;
   localparam int NB = 32;
   localparam int SB = 4;
   localparam int GT = NB * 80;
   localparam int LB = 32'h2000;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bsel_load, wr_en, lin_wr_en;
   logic [4:0] bsel_lit;
   logic [6:0] wr_off, rd_off;
   logic [7:0] wr_data, rd_data, lin_wdata, lin_rdata;
   logic [15:0] lin_addr;
   logic [4:0] bank_q;

   banked_dmem dut_i (
      .clk(clk), .rst_n(rst_n), .bsel_load(bsel_load), .bsel_lit(bsel_lit),
      .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data), .rd_off(rd_off),
      .rd_data(rd_data), .lin_wr_en(lin_wr_en), .lin_addr(lin_addr),
      .lin_wdata(lin_wdata), .lin_rdata(lin_rdata), .bank_q(bank_q));

   always #5 clk = ~clk;

   int n_chk = 0, n_fail = 0, cur_bank = 0;
   bit done = 0;
   logic [7:0] m_core [12];
   logic [7:0] m_com  [16];
   logic [7:0] m_sfr  [SB*20];
   logic [7:0] m_gpr  [GT];

   function automatic logic [7:0] exp_rd(int b, int o);
      if (o < 12)  return (o == 8) ? 8'(b) : m_core[o];
      if (o < 32)  return (b < SB) ? m_sfr[b*20 + o - 12] : 8'h00;
      if (o < 112) return m_gpr[b*80 + o - 32];
      return m_com[o - 112];
   endfunction

   function automatic logic [7:0] exp_lin(int a);
      if (a >= LB && a < LB + GT) return m_gpr[a - LB];
      return 8'h00;
   endfunction

   function automatic string req_of(int b, int o);
      if (o == 8)  return "R3";
      if (o < 12)  return "R2";
      if (o < 32)  return (b < SB) ? "R5" : "R6";
      if (o < 112) return "R7";
      return "R8";
   endfunction

   function automatic logic [7:0] pat(int b, int o);
      return 8'(b*29 + o*7 + 3);
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic model_write(int b, int o, logic [7:0] d);
      if (o == 8)        cur_bank = int'(d) % NB;
      else if (o < 12)   m_core[o] = d;
      else if (o < 32) begin
         if (b < SB) m_sfr[b*20 + o - 12] = d;
      end
      else if (o < 112)  m_gpr[b*80 + o - 32] = d;
      else               m_com[o - 112] = d;
   endtask

   task automatic set_bank(int b);
      @(negedge clk);
      bsel_load = 1'b1; bsel_lit = 5'(b);
      @(negedge clk);
      bsel_load = 1'b0;
      cur_bank = b;
   endtask

   task automatic bwrite(int o, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_off = 7'(o); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(cur_bank, o, d);
   endtask

   task automatic lwrite(int a, logic [7:0] d);
      @(negedge clk);
      lin_wr_en = 1'b1; lin_addr = 16'(a); lin_wdata = d;
      @(negedge clk);
      lin_wr_en = 1'b0;
      if (a >= LB && a < LB + GT) m_gpr[a - LB] = d;
   endtask

   task automatic bread(int o, string req);
      rd_off = 7'(o);
      #1;
      check(req, rd_data, exp_rd(cur_bank, o), $sformatf("bank %0d off %h", cur_bank, o));
   endtask

   task automatic lread(int a, string req);
      lin_addr = 16'(a);
      #1;
      check(req, lin_rdata, exp_lin(a), $sformatf("linear %h", a));
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bsel_load = 0; bsel_lit = 0; wr_en = 0; wr_off = 0; wr_data = 0;
      rd_off = 0; lin_wr_en = 0; lin_addr = 0; lin_wdata = 0;
      for (int i = 0; i < 12; i++) m_core[i] = 0;
      for (int i = 0; i < 16; i++) m_com[i] = 0;
      for (int i = 0; i < SB*20; i++) m_sfr[i] = 0;
      for (int i = 0; i < GT; i++) m_gpr[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1", 8'(bank_q), 8'h00, "bank after reset");
      for (int o = 0; o < 128; o++) bread(o, "R1");
      for (int n = 0; n < GT; n += 97) lread(LB + n, "R1");

      // fill every bank through the banked port, then read all banks back
      for (int b = 0; b < NB; b++) begin
         set_bank(b);
         for (int o = 0; o < 128; o++) if (o != 8) bwrite(o, pat(b, o));
      end
      for (int b = 0; b < NB; b++) begin
         set_bank(b);
         check("R4", 8'(bank_q), 8'(b), "literal bank load");
         for (int o = 0; o < 128; o++) bread(o, req_of(b, o));
      end

      // R3: load the bank through offset 0x08; upper bits dropped
      set_bank(0);
      bwrite(8, 8'hE5);
      check("R3", 8'(bank_q), 8'h05, "bank after offset-8 write");
      bread(8, "R3");
      bread(8'h20, "R3");
      bread(8'h6F, "R3");

      // R4: strobe beats offset-8 write in the same cycle
      @(negedge clk);
      bsel_load = 1; bsel_lit = 5'd3; wr_en = 1; wr_off = 7'h08; wr_data = 8'h09;
      @(negedge clk);
      bsel_load = 0; wr_en = 0;
      cur_bank = 3;
      check("R4", 8'(bank_q), 8'h03, "strobe priority");

      // R9: linear view of all general RAM
      for (int n = 0; n < GT; n++) lread(LB + n, "R9");
      for (int k = 0; k < 5; k++) begin
         int n;
         n = (k == 0) ? 0 : (k == 1) ? 79 : (k == 2) ? 80 : (k == 3) ? 1234 : GT - 1;
         lwrite(LB + n, ~pat(n, 1));
         set_bank(n / 80);
         bread(32 + n % 80, "R9");
      end

      // R10: outside the window
      lwrite(LB - 1, 8'hAA);
      lwrite(LB + GT, 8'hAA);
      lwrite(16'hFFFF, 8'hAA);
      lread(0, "R10");
      lread(LB - 1, "R10");
      lread(LB + GT, "R10");
      lread(16'hFFFF, "R10");
      for (int n = 0; n < GT; n++) lread(LB + n, "R10");

      // R11: write visible only after the edge; linear wins a collision
      set_bank(2);
      @(negedge clk);
      wr_en = 1; wr_off = 7'h30; wr_data = 8'h5A; rd_off = 7'h30;
      #1;
      check("R11", rd_data, exp_rd(2, 8'h30), "before edge");
      @(negedge clk);
      wr_en = 0;
      model_write(2, 8'h30, 8'h5A);
      #1;
      check("R11", rd_data, 8'h5A, "after edge");
      @(negedge clk);
      wr_en = 1; wr_off = 7'h25; wr_data = 8'h11;
      lin_wr_en = 1; lin_addr = 16'(LB + 2*80 + 5); lin_wdata = 8'h22;
      @(negedge clk);
      wr_en = 0; lin_wr_en = 0;
      m_gpr[2*80 + 5] = 8'h22;
      bread(8'h25, "R11");

      done = 1;
      summary();
      $finish;
   end
endmodule